// File: doc/BRIEF.md
# Shared-Pool Multi-Queue FIFO

This block carves one storage array into between one and four independent first-in first-out queues. The number of queues is taken from a strap input while reset is held. The pool is then divided evenly, in whole blocks of `BLK_WORDS` words, so every active queue gets the same depth. A single write port and a single read port share one clock. Each port carries its own queue number and a strobe that loads it. A producer can fill one queue while a consumer drains another, and both can move a word on every cycle.

The read side works in first-word-fall-through fashion. The head word of the selected queue sits on `rd_data` whenever `rd_valid` is high, and `rd_en` pops it. Full and almost-full describe the queue selected on the write side. Almost-empty and valid describe the queue selected on the read side. Two 4-bit buses report the almost flags of every queue at once. A partial reset empties one chosen queue and leaves the others alone. A queue number at or beyond the strapped count is a null selection and moves no data.

Top module: `mq_fifo`

## Requirements
- R1: While `rst_n` is low, `cfg_qcnt` holds the queue count minus one (0 to 3 for 1 to 4 queues). Each active queue then holds floor(`TOTAL_BLOCKS` / count) × `BLK_WORDS` words.
- R2: A queue number on `wr_sel` or `rd_sel` is loaded at a clock edge where its strobe is high. Data first moves to or from that queue at the following edge. A word written in the same cycle as the strobe goes to the previously selected queue.
- R3: `rd_valid` is high exactly when the selected read queue is active and non-empty. `rd_data` then shows its oldest word, and `rd_en` at an edge removes that word.
- R4: One write and one read complete at the same edge, including when both ports select the same queue.
- R5: `wr_full` is high when the selected write queue holds its full depth. `wr_almost_full` is high when that queue holds at least depth − `AF_OFF` words.
- R6: `rd_almost_empty` is high when the selected read queue holds at most `AE_OFF` words.
- R7: Bit i of `ae_bus` and bit i of `af_bus` give the almost-empty and almost-full state of queue i under the R5/R6 thresholds. Queues beyond the count report almost-empty 1 and almost-full 0.
- R8: `prst_en` at an edge empties queue `prst_q`, overriding any push or pop to that queue at the same edge. Every other queue keeps its words and order.
- R9: A write to a full queue, or `rd_en` while `rd_valid` is low, changes no stored word or count.
- R10: A selected queue number at or above the count is null: `rd_valid` stays low, `wr_full` reads high, `rd_almost_empty` reads high, `wr_almost_full` reads low, and no data moves.
- R11: After reset both selections are queue 0 and every queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_qcnt | input | 2 | Queue count minus one, sampled during reset |
| wr_sel_en | input | 1 | Load `wr_sel` as the write queue |
| wr_sel | input | 2 | Write queue number |
| wr_en | input | 1 | Push `wr_data` into the write queue |
| wr_data | input | DW | Word to push |
| rd_sel_en | input | 1 | Load `rd_sel` as the read queue |
| rd_sel | input | 2 | Read queue number |
| rd_en | input | 1 | Pop the head word of the read queue |
| rd_data | output | DW | Head word of the read queue |
| rd_valid | output | 1 | Head word present |
| rd_almost_empty | output | 1 | Read queue at or under the almost-empty level |
| wr_full | output | 1 | Write queue full or null |
| wr_almost_full | output | 1 | Write queue at or over the almost-full level |
| prst_en | input | 1 | Partial reset strobe |
| prst_q | input | 2 | Queue cleared by the partial reset |
| ae_bus | output | 4 | Almost-empty state, one bit per queue |
| af_bus | output | 4 | Almost-full state, one bit per queue |

## Verification
The bench builds the block with 16-bit words, 4-word blocks and an 8-block pool, and both offsets set to 2. Queues are then only 8 words deep with four or three queues, and 32 deep with one. Random traffic therefore reaches full, empty and both almost thresholds many times over. Three reset passes strap four, three and one queue. The three-queue pass makes queue 3 a null target on both ports. The one-queue pass shows the depth follow the strapped count.

// File: rtl/mq_pkg.sv
package mq_pkg;
  localparam int NQ = 4;
  localparam int QW = 2;
  typedef logic [QW-1:0] qid_t;
endpackage

// File: rtl/mq_qctl.sv
// Per-queue pointer and occupancy tracker; offsets wrap at the runtime depth.
module mq_qctl #(
  parameter int AW = 10,
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] depth,
  input  logic          push,
  input  logic          pop,
  input  logic          clr,
  output logic [AW-1:0] wr_off,
  output logic [AW-1:0] rd_off,
  output logic [CW-1:0] count
);
  logic [AW-1:0] wr_off_n, rd_off_n;
  logic [CW-1:0] count_n;
  logic          upd;

  assign upd = push | pop | clr;

  always_comb begin
    wr_off_n = wr_off;
    rd_off_n = rd_off;
    count_n  = count;
    if (push) wr_off_n = (CW'(wr_off) == depth - CW'(1)) ? '0 : wr_off + AW'(1);
    if (pop)  rd_off_n = (CW'(rd_off) == depth - CW'(1)) ? '0 : rd_off + AW'(1);
    if (push && !pop) count_n = count + CW'(1);
    if (pop && !push) count_n = count - CW'(1);
    if (clr) begin
      wr_off_n = '0;
      rd_off_n = '0;
      count_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_off <= '0;
      rd_off <= '0;
      count  <= '0;
    end else if (upd) begin
      wr_off <= wr_off_n;
      rd_off <= rd_off_n;
      count  <= count_n;
    end
  end
endmodule

// File: rtl/mq_store.sv
// Shared word array: one write port, one asynchronous read port.
module mq_store #(
  parameter int DW    = 36,
  parameter int AW    = 10,
  parameter int WORDS = 1024
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mq_fifo.sv
module mq_fifo
  import mq_pkg::*;
#(
  parameter int DW           = 36,
  parameter int BLK_WORDS    = 256,
  parameter int TOTAL_BLOCKS = 4,
  parameter int AE_OFF       = 8,
  parameter int AF_OFF       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_qcnt,
  input  logic          wr_sel_en,
  input  logic [1:0]    wr_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_sel_en,
  input  logic [1:0]    rd_sel,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rd_almost_empty,
  output logic          wr_full,
  output logic          wr_almost_full,
  input  logic          prst_en,
  input  logic [1:0]    prst_q,
  output logic [3:0]    ae_bus,
  output logic [3:0]    af_bus
);
  localparam int POOL = BLK_WORDS * TOTAL_BLOCKS;
  localparam int AW   = $clog2(POOL);
  localparam int CW   = $clog2(POOL + 1);

  function automatic logic [CW-1:0] depth_for(input logic [1:0] c);
    return CW'((TOTAL_BLOCKS / (int'(c) + 1)) * BLK_WORDS);
  endfunction

  // strapped configuration
  logic [2:0]    nq_q;
  logic [CW-1:0] depth_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nq_q    <= {1'b0, cfg_qcnt} + 3'd1;
      depth_q <= depth_for(cfg_qcnt);
    end
  end

  // port queue selection
  qid_t wq_q, rq_q, wq_n, rq_n;

  always_comb begin
    wq_n = wr_sel_en ? wr_sel : wq_q;
    rq_n = rd_sel_en ? rd_sel : rq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wq_q <= '0;
      rq_q <= '0;
    end else begin
      wq_q <= wq_n;
      rq_q <= rq_n;
    end
  end

  logic wq_live, rq_live;
  assign wq_live = {1'b0, wq_q} < nq_q;
  assign rq_live = {1'b0, rq_q} < nq_q;

  // per-queue control
  logic [AW-1:0] wr_off [NQ];
  logic [AW-1:0] rd_off [NQ];
  logic [AW-1:0] base   [NQ];
  logic [CW-1:0] cnt    [NQ];
  logic [NQ-1:0] push, pop, clr;

  for (genvar i = 0; i < NQ; i++) begin : g_q
    logic live;
    assign live    = 3'(i) < nq_q;
    assign base[i] = AW'(depth_q * CW'(i));
    assign clr[i]  = prst_en && (prst_q == QW'(i));
    assign push[i] = wr_en && wq_live && (wq_q == QW'(i)) && (cnt[i] != depth_q) && !clr[i];
    assign pop[i]  = rd_en && rq_live && (rq_q == QW'(i)) && (cnt[i] != '0) && !clr[i];
    assign ae_bus[i] = !live || (cnt[i] <= CW'(AE_OFF));
    assign af_bus[i] = live && (cnt[i] >= depth_q - CW'(AF_OFF));

    mq_qctl #(.AW(AW), .CW(CW)) u_qctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .depth  (depth_q),
      .push   (push[i]),
      .pop    (pop[i]),
      .clr    (clr[i]),
      .wr_off (wr_off[i]),
      .rd_off (rd_off[i]),
      .count  (cnt[i])
    );
  end

  // storage
  logic [AW-1:0] waddr, raddr;
  assign waddr = base[wq_q] + wr_off[wq_q];
  assign raddr = base[rq_q] + rd_off[rq_q];

  mq_store #(.DW(DW), .AW(AW), .WORDS(POOL)) u_store (
    .clk   (clk),
    .we    (|push),
    .waddr (waddr),
    .wdata (wr_data),
    .raddr (raddr),
    .rdata (rd_data)
  );

  // selected-queue flags
  assign rd_valid        = rq_live && (cnt[rq_q] != '0);
  assign rd_almost_empty = !rq_live || (cnt[rq_q] <= CW'(AE_OFF));
  assign wr_full         = !wq_live || (cnt[wq_q] == depth_q);
  assign wr_almost_full  = wq_live && (cnt[wq_q] >= depth_q - CW'(AF_OFF));
endmodule

// File: rtl/mq_fifo_chk.sv
module mq_fifo_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_sel_en,
  input logic          rd_sel_en,
  input logic [1:0]    rd_sel,
  input logic          rd_en,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          wr_full,
  input logic          wr_almost_full,
  input logic          prst_en,
  input logic [1:0]    prst_q,
  input logic [1:0]    rq_q,
  input logic [1:0]    wq_q,
  input logic [2:0]    nq_q
);
  assert_null_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel_en && ({1'b0, rd_sel} >= nq_q) |=> !rd_valid);

  assert_full_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_full && !wr_sel_en && !prst_en && !(rd_en && rd_valid && rq_q == wq_q) |=> wr_full);

  assert_head_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_en && !rd_sel_en && !prst_en |=> rd_valid && $stable(rd_data));

  assert_prst_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prst_en && (prst_q == rq_q) && !rd_sel_en |=> !rd_valid);

  assert_full_implies_af_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_full && ({1'b0, wq_q} < nq_q) |-> wr_almost_full);
endmodule

bind mq_fifo mq_fifo_chk #(.DW(DW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_sel_en      (wr_sel_en),
  .rd_sel_en      (rd_sel_en),
  .rd_sel         (rd_sel),
  .rd_en          (rd_en),
  .rd_valid       (rd_valid),
  .rd_data        (rd_data),
  .wr_full        (wr_full),
  .wr_almost_full (wr_almost_full),
  .prst_en        (prst_en),
  .prst_q         (prst_q),
  .rq_q           (rq_q),
  .wq_q           (wq_q),
  .nq_q           (nq_q)
);

// File: tb/test_mq_fifo.sv
module test_mq_fifo;
  localparam int DW = 16, BLK = 4, TOT = 8, AE = 2, AF = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    cfg_qcnt;
  logic          wr_sel_en, wr_en, rd_sel_en, rd_en, prst_en;
  logic [1:0]    wr_sel, rd_sel, prst_q;
  logic [DW-1:0] wr_data, rd_data;
  logic          rd_valid, rd_almost_empty, wr_full, wr_almost_full;
  logic [3:0]    ae_bus, af_bus;

  int checks = 0;
  int errors = 0;

  // reference model
  logic [DW-1:0] mq [4][$];
  int mwq, mrq, mnq, mdepth;

  always #2.5 clk = ~clk;

  mq_fifo #(.DW(DW), .BLK_WORDS(BLK), .TOTAL_BLOCKS(TOT), .AE_OFF(AE), .AF_OFF(AF)) i_mq_fifo (
    .clk(clk), .rst_n(rst_n), .cfg_qcnt(cfg_qcnt),
    .wr_sel_en(wr_sel_en), .wr_sel(wr_sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_sel_en(rd_sel_en), .rd_sel(rd_sel), .rd_en(rd_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_almost_empty(rd_almost_empty),
    .wr_full(wr_full), .wr_almost_full(wr_almost_full),
    .prst_en(prst_en), .prst_q(prst_q), .ae_bus(ae_bus), .af_bus(af_bus)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    wr_sel_en = 0; wr_sel = 0; wr_en = 0; wr_data = '0;
    rd_sel_en = 0; rd_sel = 0; rd_en = 0; prst_en = 0; prst_q = 0;
  endtask

  // R1: strap the queue count while reset is low
  task automatic do_reset(input int qc);
    @(negedge clk);
    rst_n = 0; cfg_qcnt = 2'(qc);
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 4; i++) mq[i].delete();
    mwq = 0; mrq = 0; mnq = qc + 1; mdepth = (TOT / mnq) * BLK;
  endtask

  task automatic compare(input string ph);
    bit rl, wl;
    int rs, ws;
    rl = mrq < mnq; wl = mwq < mnq;
    rs = mq[mrq].size(); ws = mq[mwq].size();
    check(rd_valid == (rl && rs > 0), {"R3 R10 rd_valid ", ph}, 32'(rd_valid), 32'(rl && rs > 0));
    if (rl && rs > 0)
      check(rd_data == mq[mrq][0], {"R3 R2 R4 R8 rd_data ", ph}, 32'(rd_data), 32'(mq[mrq][0]));
    check(wr_full == (!wl || ws == mdepth), {"R5 R1 R9 wr_full ", ph}, 32'(wr_full), 32'(!wl || ws == mdepth));
    check(wr_almost_full == (wl && ws >= mdepth - AF), {"R5 wr_almost_full ", ph},
          32'(wr_almost_full), 32'(wl && ws >= mdepth - AF));
    check(rd_almost_empty == (!rl || rs <= AE), {"R6 rd_almost_empty ", ph},
          32'(rd_almost_empty), 32'(!rl || rs <= AE));
    for (int i = 0; i < 4; i++) begin
      check(ae_bus[i] == (i >= mnq || mq[i].size() <= AE), {"R7 ae_bus ", ph},
            32'(ae_bus), 32'(i));
      check(af_bus[i] == (i < mnq && mq[i].size() >= mdepth - AF), {"R7 af_bus ", ph},
            32'(af_bus), 32'(i));
    end
  endtask

  task automatic step(input string ph);
    bit do_push, do_pop;
    @(posedge clk);
    do_pop  = rd_en && mrq < mnq && mq[mrq].size() > 0 && !(prst_en && prst_q == 2'(mrq));
    do_push = wr_en && mwq < mnq && mq[mwq].size() < mdepth && !(prst_en && prst_q == 2'(mwq));
    if (do_pop) void'(mq[mrq].pop_front());
    if (do_push) mq[mwq].push_back(wr_data);
    if (prst_en) mq[prst_q].delete();
    if (wr_sel_en) mwq = wr_sel;
    if (rd_sel_en) mrq = rd_sel;
    @(negedge clk);
    compare(ph);
  endtask

  task automatic run(input int n, input string ph);
    for (int c = 0; c < n; c++) begin
      int rp;
      rp = (c < n / 3) ? 25 : (c < 2 * n / 3) ? 85 : 55;
      wr_en     = ($urandom % 100) < 70;
      wr_data   = DW'($urandom);
      rd_en     = ($urandom % 100) < rp;
      wr_sel_en = ($urandom % 100) < 12;
      wr_sel    = 2'($urandom);
      rd_sel_en = ($urandom % 100) < 12;
      rd_sel    = 2'($urandom);
      prst_en   = ($urandom % 100) < 2;
      prst_q    = 2'($urandom);
      step(ph);
    end
    idle_inputs();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset(3);
    @(negedge clk);
    // R11: reset state
    check(rd_valid == 0, "R11 rd_valid after reset", 32'(rd_valid), 0);
    check(wr_full == 0, "R11 wr_full after reset", 32'(wr_full), 0);
    check(ae_bus == 4'hF, "R11 ae_bus after reset", 32'(ae_bus), 32'hF);
    check(af_bus == 4'h0, "R11 af_bus after reset", 32'(af_bus), 0);
    // R2: a write in the strobe cycle lands in the old queue
    wr_sel_en = 1; wr_sel = 1; wr_en = 1; wr_data = 16'hA001;
    step("R2");
    wr_sel_en = 0; wr_data = 16'hB002;
    step("R2");
    wr_en = 0; rd_en = 1;
    step("R2");
    rd_sel_en = 1; rd_sel = 1; rd_en = 1;
    step("R2");
    rd_sel_en = 0;
    step("R2");
    idle_inputs();
    // R4 and R8 under random traffic with four queues
    run(4000, "four queues R4 R8");
    // R10: three queues make queue 3 null
    do_reset(2);
    @(negedge clk);
    run(3000, "three queues R10");
    // R1: one queue, 32 deep
    do_reset(0);
    @(negedge clk);
    run(3000, "one queue R1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule